// File: doc/BRIEF.md
# Digit-Strobed Option Input Decoder

This block recovers a counter's configuration from four option pins that are not wired to fixed levels. Each pin is connected to one or more of the eight display digit strobes. The strobe that a pin follows selects a setting. The block watches the one-hot digit strobe together with a slot-phase flag that marks the settled second half of each digit slot. It samples the function, range, control and external decimal-point pins only in that half and records, per pin, the digits on which the pin was seen active.

The record builds up across one complete scan of all eight digits. When the scan ends, the block decodes the record into a measurement function, a gating range, five control flags and a per-digit decimal-point mask. These settings are held in registers until the next complete scan. Whenever a new scan changes the function or the range, the block raises a single-cycle restart pulse so that the measurement logic can abandon its current cycle. The pin polarity is a build parameter. This lets one design serve displays with a common anode or a common cathode.

Top module: `option_strobe_decoder`

## Requirements
- R1: After reset, func_code is 0 (frequency), range_code is 0, every control flag is 0, dp_mask is 0 and restart is 0.
- R2: A pin is sampled only in a cycle where slot_late is 1 and digit_strobe has exactly one bit set. Pin activity while slot_late is 0, or while the strobe has several bits set, has no effect on the decoded settings.
- R3: The function is decoded from the digits on which fn_pin was active. Bit 0 of digit_strobe is digit 1. The mapping is: digit 1 gives code 0 (frequency), digit 8 gives code 1 (period), digit 2 gives code 2 (ratio), digit 5 gives code 3 (time interval), digit 4 gives code 4 (unit count) and digit 3 gives code 5 (timebase self-measure). If the pin was active on no digit, on more than one digit, or only on digit 6 or 7, the previous code is kept.
- R4: The range is decoded from the digits on which rng_pin was active. Digits 1, 2, 3 and 4 give range_code 0, 1, 2 and 3, which select windows of 1, 10, 100 and 1000 events. Any other pattern keeps the previous code.
- R5: ctl_pin may be active on several digits in one scan, and each of those digits sets its own flag. Digit 8 sets disp_test, digit 2 sets clk_1mhz_sel, digit 1 sets ext_osc_en and digit 3 sets ext_dp_en. A flag whose digit is absent from the scan reads 0.
- R6: disp_off becomes 1 only when ctl_pin was active on digit 4 and hold_in is 1 in the cycle that completes the scan.
- R7: When the same scan sets ext_dp_en, dp_mask equals the set of digits on which xdp_pin was active. Otherwise dp_mask is 0.
- R8: With ACTIVE_LOW = 1 (the default), a pin at 0 is active and a pin at 1 is idle. A scan with every pin held at 1 clears all control flags and dp_mask and leaves func_code and range_code unchanged.
- R9: A scan is complete once all eight digits have been sampled. The settings change only on the clock edge of the first non-sampling cycle after that point, and they stay unchanged while a scan is still in progress.
- R10: restart is 1 for exactly one cycle, in the cycle in which the new settings appear, and only if func_code or range_code differs from its previous value. A change that affects only the flags or dp_mask does not raise restart.
- R11: While disp_off is 1 and hold_in is 1, all option pins are ignored, every setting holds and restart stays 0. One cycle after hold_in goes to 0, disp_off reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_strobe | input | 8 | One-hot digit slot indicator, bit 0 = digit 1 |
| slot_late | input | 1 | High during the settled second half of the current digit slot |
| fn_pin | input | 1 | Function option pin |
| rng_pin | input | 1 | Range option pin |
| ctl_pin | input | 1 | Control option pin, may follow several digits |
| xdp_pin | input | 1 | External decimal-point pin |
| hold_in | input | 1 | Hold request, qualifies display off and ends it |
| func_code | output | 3 | Decoded measurement function |
| range_code | output | 2 | Decoded window, log10 of the event count |
| disp_off | output | 1 | Display off active |
| disp_test | output | 1 | Display test flag |
| clk_1mhz_sel | output | 1 | Low-frequency timebase select flag |
| ext_osc_en | output | 1 | External timebase enable flag |
| ext_dp_en | output | 1 | External decimal-point enable flag |
| dp_mask | output | 8 | Digits that show an external decimal point |
| restart | output | 1 | One-cycle pulse on a change of function or range |

## Verification
The restart pulse and entry into display off can land in the same cycle. This happens when a single scan both changes the function and carries the control pin on digit 4 while hold is high. The bench builds such a scan on purpose and expects restart high together with disp_off in the update cycle. It then runs a further scan under hold with a different function and expects no second pulse and no change to any setting. Random scans also combine flag-only changes with function and range changes, and each cycle's pulse is judged against the bench's model of the previous settings.

// File: rtl/optdec_pkg.sv
package optdec_pkg;

    localparam int NDIG = 8;
    localparam int NPIN = 4;
    localparam int PIN_FN  = 0;
    localparam int PIN_RNG = 1;
    localparam int PIN_CTL = 2;
    localparam int PIN_XDP = 3;

    typedef logic [NDIG-1:0] dmask_t;

    typedef enum logic [2:0] {
        FN_FREQ     = 3'd0,
        FN_PERIOD   = 3'd1,
        FN_RATIO    = 3'd2,
        FN_INTERVAL = 3'd3,
        FN_UNIT     = 3'd4,
        FN_SELFOSC  = 3'd5
    } func_e;

    typedef struct packed {
        dmask_t xdp;
        dmask_t ctl;
        dmask_t rng;
        dmask_t fn;
    } hits_t;

    typedef struct packed {
        func_e      func;
        logic [1:0] rng;
        logic       off;
        logic       test;
        logic       mhz1;
        logic       extosc;
        logic       extdp;
        dmask_t     dp;
    } setting_t;

    localparam setting_t SETTING_RESET = '{func: FN_FREQ, rng: 2'd0, off: 1'b0,
                                           test: 1'b0, mhz1: 1'b0, extosc: 1'b0,
                                           extdp: 1'b0, dp: '0};

    function automatic func_e decode_func(input dmask_t m, input func_e prev);
        case (m)
            8'h01:   return FN_FREQ;
            8'h80:   return FN_PERIOD;
            8'h02:   return FN_RATIO;
            8'h10:   return FN_INTERVAL;
            8'h08:   return FN_UNIT;
            8'h04:   return FN_SELFOSC;
            default: return prev;
        endcase
    endfunction

    function automatic logic [1:0] decode_range(input dmask_t m, input logic [1:0] prev);
        case (m)
            8'h01:   return 2'd0;
            8'h02:   return 2'd1;
            8'h04:   return 2'd2;
            8'h08:   return 2'd3;
            default: return prev;
        endcase
    endfunction

endpackage

// File: rtl/optdec_sampler.sv
module optdec_sampler
    import optdec_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  dmask_t          strobe,
    input  logic            slot_late,
    input  logic [NPIN-1:0] pins,
    input  logic            freeze,
    output hits_t           hits,
    output logic            frame_done
);

    logic [NPIN-1:0]           act;
    logic [NPIN-1:0][NDIG-1:0] hit_q;
    dmask_t                    seen_q;
    logic                      sample_ok;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign act = ~pins;
        end else begin : g_high
            assign act = pins;
        end
    endgenerate

    assign sample_ok  = slot_late & $onehot(strobe);
    assign frame_done = (&seen_q) & ~sample_ok;

    always_ff @(posedge clk) begin
        if (rst || freeze || frame_done) begin
            seen_q <= '0;
            hit_q  <= '0;
        end else if (sample_ok) begin
            seen_q <= seen_q | strobe;
            for (int p = 0; p < NPIN; p++) begin
                if (act[p]) hit_q[p] <= hit_q[p] | strobe;
            end
        end
    end

    assign hits.fn  = hit_q[PIN_FN];
    assign hits.rng = hit_q[PIN_RNG];
    assign hits.ctl = hit_q[PIN_CTL];
    assign hits.xdp = hit_q[PIN_XDP];

    // R2: outside a late, single-strobe cycle nothing is recorded
    p_early_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (!sample_ok && !freeze && !frame_done) |=> ($stable(hit_q) && $stable(seen_q)));

    // R11: a frozen sampler holds no record
    p_freeze_clears_r11: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (seen_q == '0));

endmodule

// File: rtl/optdec_decode.sv
module optdec_decode
    import optdec_pkg::*;
(
    input  hits_t    hits,
    input  setting_t prev,
    input  logic     hold_in,
    output setting_t next
);

    always_comb begin
        next        = prev;
        next.func   = decode_func(hits.fn, prev.func);
        next.rng    = decode_range(hits.rng, prev.rng);
        next.extosc = hits.ctl[0];
        next.mhz1   = hits.ctl[1];
        next.extdp  = hits.ctl[2];
        next.off    = hits.ctl[3] & hold_in;
        next.test   = hits.ctl[7];
        next.dp     = hits.ctl[2] ? hits.xdp : '0;
    end

    // R7: the decimal-point mask never appears without its enable
    always_comb begin
        a_dp_gated_r7: assert (next.extdp || next.dp == '0);
    end

endmodule

// File: rtl/option_strobe_decoder.sv
module option_strobe_decoder
    import optdec_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] digit_strobe,
    input  logic       slot_late,
    input  logic       fn_pin,
    input  logic       rng_pin,
    input  logic       ctl_pin,
    input  logic       xdp_pin,
    input  logic       hold_in,
    output logic [2:0] func_code,
    output logic [1:0] range_code,
    output logic       disp_off,
    output logic       disp_test,
    output logic       clk_1mhz_sel,
    output logic       ext_osc_en,
    output logic       ext_dp_en,
    output logic [7:0] dp_mask,
    output logic       restart
);

    setting_t cur_q, nxt;
    hits_t    hits;
    logic     frame_done;
    logic     commit;
    logic     restart_q;

    optdec_sampler #(.ACTIVE_LOW(ACTIVE_LOW)) u_samp (
        .clk        (clk),
        .rst        (rst),
        .strobe     (digit_strobe),
        .slot_late  (slot_late),
        .pins       ({xdp_pin, ctl_pin, rng_pin, fn_pin}),
        .freeze     (cur_q.off),
        .hits       (hits),
        .frame_done (frame_done)
    );

    optdec_decode u_dec (
        .hits    (hits),
        .prev    (cur_q),
        .hold_in (hold_in),
        .next    (nxt)
    );

    assign commit = frame_done & ~cur_q.off;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= SETTING_RESET;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (cur_q.off) begin
                if (!hold_in) cur_q.off <= 1'b0;
            end else if (commit) begin
                cur_q     <= nxt;
                restart_q <= (nxt.func != cur_q.func) || (nxt.rng != cur_q.rng);
            end
        end
    end

    assign func_code    = cur_q.func;
    assign range_code   = cur_q.rng;
    assign disp_off     = cur_q.off;
    assign disp_test    = cur_q.test;
    assign clk_1mhz_sel = cur_q.mhz1;
    assign ext_osc_en   = cur_q.extosc;
    assign ext_dp_en    = cur_q.extdp;
    assign dp_mask      = cur_q.dp;
    assign restart      = restart_q;

    // R10: never two pulses back to back
    p_restart_single_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);

    // R10: a pulse always accompanies a new function or range
    p_restart_cause_r10: assert property (@(posedge clk) disable iff (rst)
        restart |-> ((func_code != $past(func_code)) || (range_code != $past(range_code))));

    // R9: settings move only after a completed scan
    p_update_on_frame_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(func_code) || !$stable(range_code)) |-> $past(frame_done));

    // R11: under display off with hold, everything stays put
    p_hold_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        (disp_off && hold_in) |=> ($stable(func_code) && $stable(range_code)
                                   && $stable(dp_mask) && !restart && disp_off));

endmodule

// File: tb/tb_option_strobe_decoder.sv
module tb_option_strobe_decoder;

    localparam bit ACT_LOW = 1'b1;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] digit_strobe;
    logic       slot_late, fn_pin, rng_pin, ctl_pin, xdp_pin, hold_in;
    logic [2:0] func_code;
    logic [1:0] range_code;
    logic       disp_off, disp_test, clk_1mhz_sel, ext_osc_en, ext_dp_en, restart;
    logic [7:0] dp_mask;

    always #2.5 clk = ~clk;

    option_strobe_decoder #(.ACTIVE_LOW(ACT_LOW)) dut (
        .clk(clk), .rst(rst), .digit_strobe(digit_strobe), .slot_late(slot_late),
        .fn_pin(fn_pin), .rng_pin(rng_pin), .ctl_pin(ctl_pin), .xdp_pin(xdp_pin),
        .hold_in(hold_in), .func_code(func_code), .range_code(range_code),
        .disp_off(disp_off), .disp_test(disp_test), .clk_1mhz_sel(clk_1mhz_sel),
        .ext_osc_en(ext_osc_en), .ext_dp_en(ext_dp_en), .dp_mask(dp_mask),
        .restart(restart)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [2:0] e_func;
    logic [1:0] e_rng;
    logic [4:0] e_flags;
    logic [7:0] e_dp;
    logic       e_off, e_rs;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] m_func(input logic [7:0] m, input logic [2:0] p);
        case (m)
            8'h01: return 3'd0;
            8'h80: return 3'd1;
            8'h02: return 3'd2;
            8'h10: return 3'd3;
            8'h08: return 3'd4;
            8'h04: return 3'd5;
            default: return p;
        endcase
    endfunction

    function automatic logic [1:0] m_rng(input logic [7:0] m, input logic [1:0] p);
        case (m)
            8'h01: return 2'd0;
            8'h02: return 2'd1;
            8'h04: return 2'd2;
            8'h08: return 2'd3;
            default: return p;
        endcase
    endfunction

    function automatic logic [4:0] out_flags();
        return {disp_off, disp_test, clk_1mhz_sel, ext_osc_en, ext_dp_en};
    endfunction

    task automatic drive(input logic [7:0] s, input logic late, input logic [3:0] act);
        @(negedge clk);
        digit_strobe = s;
        slot_late    = late;
        {xdp_pin, ctl_pin, rng_pin, fn_pin} = act ^ {4{ACT_LOW}};
    endtask

    // One full scan of the eight digits followed by the update and a quiet cycle
    task automatic frame(input logic [7:0] fm, input logic [7:0] rm, input logic [7:0] cm,
                         input logic [7:0] xm, input logic hold, input bit noise);
        logic [2:0] nf;
        logic [1:0] nr;
        hold_in = hold;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] s;
            logic [3:0] a;
            s = 8'h01 << k;
            a = {xm[k], cm[k], rm[k], fm[k]};
            drive(s, 1'b0, noise ? 4'hF : 4'h0);
            drive(s, 1'b0, noise ? 4'hF : 4'h0);
            drive(s, 1'b1, a);
            drive(s, 1'b1, a);
            if (noise && k == 4) drive(8'h03, 1'b1, 4'hF);
        end
        @(negedge clk);
        check("R9 pre-update func", func_code, e_func);
        check("R9 pre-update range", range_code, e_rng);
        digit_strobe = 8'h01;
        slot_late    = 1'b0;
        {xdp_pin, ctl_pin, rng_pin, fn_pin} = {4{ACT_LOW}};
        if (!e_off) begin
            nf      = m_func(fm, e_func);
            nr      = m_rng(rm, e_rng);
            e_rs    = (nf != e_func) || (nr != e_rng);
            e_func  = nf;
            e_rng   = nr;
            e_off   = cm[3] & hold;
            e_flags = {cm[3] & hold, cm[7], cm[1], cm[0], cm[2]};
            e_dp    = cm[2] ? xm : 8'h00;
        end else begin
            e_rs = 1'b0;
        end
        @(negedge clk);
        check("R3 func_code", func_code, e_func);
        check("R4 range_code", range_code, e_rng);
        check("R5 R6 flags", out_flags(), e_flags);
        check("R7 dp_mask", dp_mask, e_dp);
        check("R10 restart pulse", restart, e_rs);
        @(negedge clk);
        check("R10 restart single cycle", restart, 1'b0);
    endtask

    task automatic leave_off();
        @(negedge clk);
        hold_in = 1'b0;
        @(negedge clk);
        check("R11 display off released", disp_off, 1'b0);
        e_off      = 1'b0;
        e_flags[4] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        rst = 1'b1;
        digit_strobe = 8'h00;
        slot_late = 1'b0;
        {xdp_pin, ctl_pin, rng_pin, fn_pin} = {4{ACT_LOW}};
        hold_in = 1'b0;
        e_func = 3'd0; e_rng = 2'd0; e_flags = 5'd0; e_dp = 8'd0; e_off = 1'b0; e_rs = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset func", func_code, 3'd0);
        check("R1 reset range", range_code, 2'd0);
        check("R1 reset flags", out_flags(), 5'd0);
        check("R1 reset dp", dp_mask, 8'd0);
        check("R1 reset restart", restart, 1'b0);
        rst = 1'b0;

        frame(8'h80, 8'h04, 8'h00, 8'h00, 1'b0, 0);   // period, 100 events
        frame(8'h80, 8'h04, 8'h00, 8'h00, 1'b0, 0);   // repeat: no pulse
        frame(8'h80, 8'h04, 8'h83, 8'h00, 1'b0, 0);   // flags only
        frame(8'h80, 8'h04, 8'h83, 8'h00, 1'b0, 1);   // R2 early-half and multi-strobe noise
        frame(8'h40, 8'h21, 8'h00, 8'h00, 1'b0, 0);   // R3 R4 invalid patterns hold
        frame(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 0);   // R8 all pins idle high
        check("R8 idle scan clears flags", out_flags(), 5'd0);
        frame(8'h01, 8'h08, 8'h04, 8'h10, 1'b0, 0);   // R7 dp on digit 5
        frame(8'h01, 8'h08, 8'h00, 8'h10, 1'b0, 0);   // R7 dp without enable
        frame(8'h10, 8'h08, 8'h08, 8'h00, 1'b1, 0);   // R6 R10 restart with display off
        check("R6 display off entered", disp_off, 1'b1);
        frame(8'h04, 8'h01, 8'h80, 8'hFF, 1'b1, 0);   // R11 ignored while off
        leave_off();
        frame(8'h08, 8'h08, 8'h08, 8'h00, 1'b0, 0);   // R6 digit 4 without hold

        for (int i = 0; i < 50; i++) begin
            logic [7:0] fm, rm, cm, xm;
            logic       h;
            fm = ($urandom % 4 == 0) ? 8'($urandom) : 8'h01 << ($urandom % 8);
            rm = ($urandom % 4 == 0) ? 8'($urandom) : 8'h01 << ($urandom % 5);
            cm = 8'($urandom);
            xm = 8'($urandom);
            h  = ($urandom % 6 == 0);
            frame(fm, rm, cm, xm, h, ($urandom % 5 == 0));
            if (e_off) begin
                frame(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b1, 0);
                leave_off();
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule